// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm and Periodic Interrupt

This block is a real-time clock core. It runs on the system clock and advances on a timebase enable pulse that arrives once per 32.768 kHz cycle. It keeps seconds, minutes, hours (24-hour form), day of month, month and a two-digit year, all in packed BCD. The calendar covers 100 years. Month lengths are applied, and February gains a 29th day in leap years. A host reaches the clock through a small register file. The register file uses a 4-bit address, separate 8-bit write and read data buses, a read-drive enable, and chip select, write and output strobes.

There are two interrupt sources, and both drive one interrupt line. The first is an alarm that compares four time fields. Each of those fields can be masked, so the alarm can repeat at any rate from every second up to once a month. The second is a periodic timer whose period is a power of two between one timebase cycle and 16384 cycles. Each source sets a sticky flag. Reading the flag register clears the flags. A backup-mode input blocks the periodic source from reaching the line, but the alarm can still raise it.

Register map:

| Address | Register |
|---------|----------|
| 0 | seconds |
| 1 | minutes |
| 2 | hours |
| 3 | day |
| 4 | month |
| 5 | year |
| 6 | alarm seconds |
| 7 | alarm minutes |
| 8 | alarm hours |
| 9 | alarm day |
| 0xA | control |
| 0xB | flags |

Top module: `rtc_core`

## Requirements
- R1: After reset the time reads 00:00:00, day 01, month 01, year 00. The control and flag registers read 0, and int_o is low.
- R2: Seconds advance by one every TICKS_PER_SEC timebase ticks. All fields count in packed BCD (09 is followed by 10). Seconds 59 wraps to 00 and carries into minutes. Minutes 59 wraps to 00 and carries into hours. Hours 23 wraps to 00 and carries into the day.
- R3: When the day passes the month's length, it becomes 01 and the month increments. April, June, September and November have 30 days. The other months except February have 31. Month 12 wraps to 01 and increments the year. Year 99 wraps to 00.
- R4: February has 29 days when the BCD year is divisible by 4, including 00. Otherwise it has 28.
- R5: A write to addresses 0–5 becomes visible only after the next timebase tick. On that tick the seconds prescaler restarts, so the next advance comes TICKS_PER_SEC ticks later.
- R6: While cs_i stays high, reads of addresses 0–5 return the time as it stood before cs_i rose, even if the clock advances meanwhile.
- R7: Alarm registers 6–9 compare against seconds, minutes, hours and day. Bit 7 set masks a field. On each second advance, if every unmasked field equals the new time, flag bit 0 sets.
- R8: Control bits [3:0] hold a rate n. n = 0 stops the periodic source. n = 1..15 sets flag bit 1 once every 2^(n-1) timebase ticks.
- R9: Flags stay set until the host reads address 0xB. When that read access ends, only the bits it returned are cleared.
- R10: int_o is high when either of these holds: flag bit 0 is set and control bit 4 is set, or flag bit 1 is set, control bit 5 is set and backup_i is low.
- R11: Control bits [5:0] read back at address 0xA. data_oe_o is high exactly when cs_i and oe_i are high and we_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per 32.768 kHz timebase cycle |
| backup_i | input | 1 | Backup mode; only the alarm may raise int_o |
| cs_i | input | 1 | Register chip select |
| we_i | input | 1 | Write strobe |
| oe_i | input | 1 | Read (output) strobe |
| addr_i | input | 4 | Register address |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data |
| data_oe_o | output | 1 | Read data drive enable |
| int_o | output | 1 | Combined interrupt |

## Verification
The hardest states to reach are the calendar boundaries: a year wrap, February in leap and common years, and a 30-day month end. With a real timebase these take months of simulated time. The bench sets TICKS_PER_SEC to 4 and drives ticks one at a time. It loads a time one second before each boundary through the deferred-write path, then issues exactly the ticks that one advance needs. The periodic period is measured by counting ticks between successive flag reads, so the free-running phase of the divider does not affect the result.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int N_TIME = 6;
  localparam int N_ALM  = 4;
  localparam logic [3:0] A_ALM0 = 4'h6;
  localparam logic [3:0] A_CTRL = 4'hA;
  localparam logic [3:0] A_FLAG = 4'hB;

  typedef logic [N_TIME-1:0][7:0] rtc_time_t;  // 0 sec .. 5 year
  typedef logic [N_ALM-1:0][7:0]  rtc_alm_t;

  function automatic logic [7:0] bcd_inc(logic [7:0] v);
    if (v[3:0] >= 4'h9) return {v[7:4] + 4'd1, 4'h0};
    return v + 8'd1;
  endfunction

  function automatic logic is_leap(logic [7:0] yr);
    if (yr[4]) return (yr[3:0] == 4'h2) || (yr[3:0] == 4'h6);
    return (yr[3:0] == 4'h0) || (yr[3:0] == 4'h4) || (yr[3:0] == 4'h8);
  endfunction

  function automatic logic [7:0] month_len(logic [7:0] mon, logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_timebase.sv
`timescale 1ns/1ps
module rtc_timebase #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int PER_W         = 14
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       load_i,
  input  logic [3:0] rate_i,
  output logic       sec_adv_o,
  output logic       per_hit_o
);
  localparam int PS_W = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(TICKS_PER_SEC - 1);

  logic [PS_W-1:0]  ps_q;
  logic [PER_W-1:0] pcnt_q;
  logic [PER_W-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ps_q <= '0;
    else if (tick_i) begin
      if (load_i || ps_q == PS_LAST) ps_q <= '0;
      else                           ps_q <= ps_q + 1'b1;
    end
  end

  assign sec_adv_o = tick_i && !load_i && (ps_q == PS_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pcnt_q <= '0;
    else if (tick_i) pcnt_q <= pcnt_q + 1'b1;
  end

  // period 2^(n-1): hit when the low n-1 bits are all ones
  always_comb begin
    mask = '0;
    if (rate_i != 4'd0) mask = ({{(PER_W-1){1'b0}}, 1'b1} << (rate_i - 4'd1)) - 1'b1;
  end

  assign per_hit_o = tick_i && (rate_i != 4'd0) && ((pcnt_q & mask) == mask);

  a_r2_adv_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_adv_o |=> !sec_adv_o);
  a_r5_load_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && load_i) |=> (ps_q == '0));
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sec_adv_i,
  input  logic              load_i,
  input  logic [N_TIME-1:0] ld_mask_i,
  input  rtc_time_t         ld_val_i,
  output rtc_time_t         time_o
);
  rtc_time_t t_q, nxt;
  logic [7:0] dim;

  assign dim = month_len(t_q[4], t_q[5]);

  always_comb begin
    nxt = t_q;
    if (t_q[0] >= 8'h59) begin
      nxt[0] = 8'h00;
      if (t_q[1] >= 8'h59) begin
        nxt[1] = 8'h00;
        if (t_q[2] >= 8'h23) begin
          nxt[2] = 8'h00;
          if (t_q[3] >= dim) begin
            nxt[3] = 8'h01;
            if (t_q[4] >= 8'h12) begin
              nxt[4] = 8'h01;
              nxt[5] = (t_q[5] >= 8'h99) ? 8'h00 : bcd_inc(t_q[5]);
            end else nxt[4] = bcd_inc(t_q[4]);
          end else nxt[3] = bcd_inc(t_q[3]);
        end else nxt[2] = bcd_inc(t_q[2]);
      end else nxt[1] = bcd_inc(t_q[1]);
    end else nxt[0] = bcd_inc(t_q[0]);
  end

  for (genvar g = 0; g < N_TIME; g++) begin : g_field
    localparam logic [7:0] RST_V = (g == 3 || g == 4) ? 8'h01 : 8'h00;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    t_q[g] <= RST_V;
      else if (load_i)                t_q[g] <= ld_mask_i[g] ? ld_val_i[g] : t_q[g];
      else if (sec_adv_i)             t_q[g] <= nxt[g];
    end
  end

  assign time_o = t_q;

  a_r2_sec_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_adv_i && !load_i && t_q[0] == 8'h59) |=> (t_q[0] == 8'h00));
  a_r5_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_adv_i && !load_i) |=> $stable(t_q));
  a_r3_day_never_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_adv_i |=> (t_q[3] != 8'h00));
endmodule

// File: rtl/rtc_alarm.sv
`timescale 1ns/1ps
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic [N_ALM-1:0][7:0] now_i,
  input  rtc_alm_t              alm_i,
  input  logic                  check_i,
  output logic                  hit_o
);
  logic [N_ALM-1:0] fm;

  for (genvar g = 0; g < N_ALM; g++) begin : g_cmp
    assign fm[g] = alm_i[g][7] || (now_i[g] == {1'b0, alm_i[g][6:0]});
  end

  assign hit_o = check_i && (&fm);
endmodule

// File: rtl/rtc_core.sv
`timescale 1ns/1ps
module rtc_core
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       backup_i,
  input  logic       cs_i,
  input  logic       we_i,
  input  logic       oe_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] data_i,
  output logic [7:0] data_o,
  output logic       data_oe_o,
  output logic       int_o
);
  localparam int PER_W = 14;  // rate 15 -> 16384 ticks

  rtc_time_t         pend_q, time_w, vis_q;
  logic [N_TIME-1:0] pmask_q;
  rtc_alm_t          alm_q;
  logic [5:0]        ctrl_q;
  logic [1:0]        flags_q, seen_q;
  logic              rd_q, chk_q;
  logic              wr, load, sec_adv, per_hit, alm_hit, rd_flag, rd_end;

  assign wr   = cs_i && we_i;
  assign load = tick_i && (|pmask_q);

  // deferred time writes
  for (genvar g = 0; g < N_TIME; g++) begin : g_pend
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[g]  <= '0;
        pmask_q[g] <= 1'b0;
      end else if (wr && addr_i == 4'(g)) begin
        pend_q[g]  <= data_i;
        pmask_q[g] <= 1'b1;
      end else if (load) pmask_q[g] <= 1'b0;
    end
  end

  for (genvar g = 0; g < N_ALM; g++) begin : g_alm
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            alm_q[g] <= '0;
      else if (wr && addr_i == A_ALM0 + 4'(g)) alm_q[g] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       ctrl_q <= '0;
    else if (wr && addr_i == A_CTRL)   ctrl_q <= data_i[5:0];
  end

  rtc_timebase #(.TICKS_PER_SEC(TICKS_PER_SEC), .PER_W(PER_W)) u_tb (
    .clk_i, .rst_ni, .tick_i, .load_i(load), .rate_i(ctrl_q[3:0]),
    .sec_adv_o(sec_adv), .per_hit_o(per_hit)
  );

  rtc_calendar u_cal (
    .clk_i, .rst_ni, .sec_adv_i(sec_adv), .load_i(load),
    .ld_mask_i(pmask_q), .ld_val_i(pend_q), .time_o(time_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_q <= 1'b0;
    else         chk_q <= sec_adv;
  end

  rtc_alarm u_alm (
    .now_i(time_w[3:0]), .alm_i(alm_q), .check_i(chk_q), .hit_o(alm_hit)
  );

  // user-visible copy frozen while selected
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vis_q <= '0;
      vis_q[3] <= 8'h01;
      vis_q[4] <= 8'h01;
    end else if (!cs_i) vis_q <= time_w;
  end

  // flags: clear only what the finished read returned
  assign rd_flag = cs_i && oe_i && !we_i && (addr_i == A_FLAG);
  assign rd_end  = rd_q && !rd_flag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= 1'b0;
      seen_q  <= '0;
      flags_q <= '0;
    end else begin
      rd_q <= rd_flag;
      if (rd_flag) seen_q <= flags_q;
      flags_q <= (flags_q & ~(rd_end ? seen_q : 2'b00)) | {per_hit, alm_hit};
    end
  end

  always_comb begin
    case (addr_i)
      4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5: data_o = vis_q[addr_i[2:0]];
      4'h6:   data_o = alm_q[0];
      4'h7:   data_o = alm_q[1];
      4'h8:   data_o = alm_q[2];
      4'h9:   data_o = alm_q[3];
      A_CTRL: data_o = {2'b00, ctrl_q};
      A_FLAG: data_o = {6'b0, flags_q};
      default: data_o = '0;
    endcase
  end

  assign data_oe_o = cs_i && oe_i && !we_i;
  assign int_o = (flags_q[0] && ctrl_q[4]) || (flags_q[1] && ctrl_q[5] && !backup_i);

  a_r9_alarm_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q[0] && !rd_end) |=> flags_q[0]);
  a_r9_per_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q[1] && !rd_end) |=> flags_q[1]);
  a_r6_snapshot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_i |=> $stable(vis_q));
  a_r10_backup_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (backup_i && !ctrl_q[4]) |-> !int_o);
  a_r7_alarm_after_adv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alm_hit |-> $past(sec_adv));
endmodule

// File: tb/rtc_core_tb.sv
`timescale 1ns/1ps
module rtc_core_tb_top;
  localparam int TPS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, backup = 0, cs = 0, we = 0, oe = 0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rd_oe, irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_core #(.TICKS_PER_SEC(TPS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .backup_i(backup),
    .cs_i(cs), .we_i(we), .oe_i(oe), .addr_i(addr), .data_i(wdata),
    .data_o(rdata), .data_oe_o(rd_oe), .int_o(irq)
  );

  task automatic check(string req, logic [47:0] act, logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; oe = 1; addr = a;
    @(negedge clk); d = rdata; cs = 0; oe = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic rd_time(output logic [47:0] t);
    logic [7:0] b;
    for (int i = 5; i >= 0; i--) begin
      rd(4'(i), b);
      t[i*8 +: 8] = b;
    end
  endtask

  // {yr,mon,day,hr,min,sec}, loaded by one tick
  task automatic set_time(logic [47:0] t);
    for (int i = 0; i < 6; i++) wr(4'(i), t[i*8 +: 8]);
    ticks(1);
  endtask

  task automatic t_reset;
    logic [47:0] t; logic [7:0] b;
    rd_time(t); check("R1 time", t, 48'h00_01_01_00_00_00);
    rd(4'hA, b); check("R1 ctrl", b, 0);
    rd(4'hB, b); check("R1 flags", b, 0);
    check("R1 int", irq, 0);
  endtask

  task automatic step_check(string req, logic [47:0] from, logic [47:0] to);
    logic [47:0] t;
    set_time(from);
    ticks(TPS);
    rd_time(t); check(req, t, to);
  endtask

  task automatic t_calendar;
    step_check("R2 bcd digit", 48'h00_01_01_00_00_09, 48'h00_01_01_00_00_10);
    step_check("R2 min carry", 48'h00_01_01_00_00_59, 48'h00_01_01_00_01_00);
    step_check("R2 hour carry", 48'h07_05_10_13_59_59, 48'h07_05_10_14_00_00);
    step_check("R3 year wrap", 48'h99_12_31_23_59_59, 48'h00_01_01_00_00_00);
    step_check("R3 30-day", 48'h25_04_30_23_59_59, 48'h25_05_01_00_00_00);
    step_check("R3 31-day", 48'h25_01_31_23_59_59, 48'h25_02_01_00_00_00);
    step_check("R3 31-day keep", 48'h25_07_30_23_59_59, 48'h25_07_31_00_00_00);
    step_check("R4 leap 00", 48'h00_02_28_23_59_59, 48'h00_02_29_00_00_00);
    step_check("R4 leap 12", 48'h12_02_28_23_59_59, 48'h12_02_29_00_00_00);
    step_check("R4 leap end", 48'h12_02_29_23_59_59, 48'h12_03_01_00_00_00);
    step_check("R4 common", 48'h01_02_28_23_59_59, 48'h01_03_01_00_00_00);
  endtask

  task automatic t_load;
    logic [7:0] b;
    set_time(48'h10_06_15_12_00_20);
    wr(4'h0, 8'h45);
    rd(4'h0, b); check("R5 before tick", b, 8'h20);
    ticks(1);
    rd(4'h0, b); check("R5 after tick", b, 8'h45);
    ticks(TPS - 1);
    rd(4'h0, b); check("R5 no early adv", b, 8'h45);
    ticks(1);
    rd(4'h0, b); check("R5 adv on schedule", b, 8'h46);
  endtask

  task automatic t_snapshot;
    logic [7:0] b;
    set_time(48'h10_06_15_12_00_30);
    @(negedge clk); cs = 1; oe = 1; addr = 4'h0;
    for (int i = 0; i < TPS + 1; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
    @(negedge clk); b = rdata; cs = 0; oe = 0;
    check("R6 frozen", b, 8'h30);
    rd(4'h0, b); check("R6 released", b, 8'h31);
  endtask

  task automatic t_alarm;
    logic [7:0] b;
    wr(4'h6, 8'h05); wr(4'h7, 8'h80); wr(4'h8, 8'h80); wr(4'h9, 8'h80);
    set_time(48'h00_01_01_00_00_03);
    rd(4'hB, b);
    ticks(TPS); rd(4'hB, b); check("R7 sec mismatch", b[0], 0);
    ticks(TPS); rd(4'hB, b); check("R7 sec match", b[0], 1);
    rd(4'hB, b); check("R9 cleared by read", b[0], 0);
    wr(4'h6, 8'h80); wr(4'h7, 8'h02);
    set_time(48'h00_01_01_00_01_58);
    rd(4'hB, b);
    ticks(TPS); rd(4'hB, b); check("R7 min mismatch", b[0], 0);
    ticks(TPS); rd(4'hB, b); check("R7 min match", b[0], 1);
    wr(4'h7, 8'h80);
    rd(4'hB, b);
    ticks(TPS); ticks(TPS); rd(4'hB, b); check("R9 sticky", b[0], 1);
  endtask

  task automatic measure(logic [3:0] n, int exp);
    logic [7:0] b; int first = -1; int gap = -1;
    wr(4'hA, {4'h0, n});
    rd(4'hB, b);
    for (int i = 0; i < 40; i++) begin
      ticks(1); rd(4'hB, b);
      if (b[1]) begin
        if (first < 0) first = i;
        else begin gap = i - first; break; end
      end
    end
    check($sformatf("R8 rate %0d", n), gap, exp);
  endtask

  task automatic t_periodic;
    measure(4'd1, 1);
    measure(4'd3, 4);
    measure(4'd5, 16);
    measure(4'd0, -1);
  endtask

  task automatic t_irq_ctrl;
    logic [7:0] b;
    wr(4'hA, 8'h21);
    rd(4'hA, b); check("R11 ctrl readback", b, 8'h21);
    wr(4'h6, 8'h80); wr(4'h7, 8'h80);
    rd(4'hB, b);
    ticks(1); @(negedge clk);
    check("R10 periodic irq", irq, 1);
    backup = 1; @(negedge clk);
    check("R10 backup blocks periodic", irq, 0);
    backup = 0;
    wr(4'hA, 8'h10);
    rd(4'hB, b); @(negedge clk);
    check("R10 low after clear", irq, 0);
    backup = 1;
    ticks(TPS); @(negedge clk); @(negedge clk);
    check("R10 alarm in backup", irq, 1);
    backup = 0;
    @(negedge clk); cs = 1; oe = 1; addr = 4'hA; #1;
    check("R11 oe on read", rd_oe, 1);
    we = 1; #1;
    check("R11 oe off on write", rd_oe, 0);
    @(negedge clk); cs = 0; oe = 0; we = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_calendar;
    t_load;
    t_snapshot;
    t_alarm;
    t_periodic;
    t_irq_ctrl;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule